// File: doc/BRIEF.md
# ADC Multiplexer Frame Sequencer

This block sets the rhythm of a multi-channel sampling front end. It runs on the slow sample clock and produces a multiplexer frame that repeats without end. Each frame starts with one settle cycle, during which the converter reference recovers from the previous channel switch. After the settle cycle the sequencer steps through a programmable number of conversion slots in ascending order.

Every slot lasts a whole number of slow-clock cycles, either 1, 2 or 3. A two-bit filter-length code chooses the value. A frame is therefore `1 + N * L` slow-clock cycles long, where N is the conversion count and L is the slot length. Five outputs follow the frame:

- a frame-sync pulse that marks the settle cycle;
- a flag that is high during conversion slots;
- the index of the current slot;
- a strobe on the first cycle of each slot, which starts a conversion;
- a strobe on the last cycle of each slot, which asks for that conversion's result to be written into RAM.

The configuration is sampled only during the settle cycle, so a frame is never cut or stretched halfway through. Downstream logic on the fast processing clock, which runs at 150 times the slow clock, can align its code pass to the frame-sync pulse. All pins are plain control signals: no data flows through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `mux_frame_seq`

## Requirements
- R1: While `rst_n` is low, `frame_sync`, `conv_active`, `conv_start` and `conv_done` are 0 and `mux_slot` is 0. The first cycle after the first rising clock edge with `rst_n` high is a settle cycle.
- R2: `frame_sync` is 1 during the settle cycle and 0 otherwise. It is high for exactly one cycle per frame, and `conv_active` is 0 during that cycle.
- R3: The distance between consecutive `frame_sync` pulses is `1 + N * L` cycles. N and L are the values latched at the settle cycle that opened the frame.
- R4: During conversion, `conv_active` is 1 and `mux_slot` takes the values 0, 1, …, N-1 in order. Each value is held for exactly L consecutive cycles, and the last slot is followed directly by the next settle cycle.
- R5: `conv_start` is 1 on the first cycle of each slot and `conv_done` is 1 on the last cycle of each slot. When L = 1, both are 1 in the same cycle. While either strobe is 1, `mux_slot` names the slot concerned.
- R6: The filter-length code `cfg_flen` maps to the slot length L as follows: 0 gives L = 1, 1 gives L = 2, 2 gives L = 3. Code 3 is reserved and behaves as code 2 (L = 3).
- R7: A `cfg_count` value of 0 is treated as N = 1.
- R8: `cfg_count` and `cfg_flen` are sampled only at the clock edge that ends a settle cycle. Changing them at any other time has no effect on the frame in progress.
- R9: `mux_slot` is 0 during the settle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_count | input | CNT_W | Number of conversion slots per frame (0 acts as 1) |
| cfg_flen | input | 2 | Filter-length code that selects the slot length |
| frame_sync | output | 1 | High during the settle cycle that opens each frame |
| conv_active | output | 1 | High during conversion slots |
| mux_slot | output | CNT_W | Current slot index (0 during settle) |
| conv_start | output | 1 | First cycle of a slot: start a conversion |
| conv_done | output | 1 | Last cycle of a slot: write that slot's result to RAM |

## Verification
The bench sweeps every conversion count from 0 to 15 against all four filter codes. It compares each output in every cycle with an arithmetic position-in-frame model, and it measures each frame length between sync pulses.

- A count of 0 that is not clamped would show up as a frame with no slots, or as a slot counter that wraps.
- Code 3 decoded as a fourth length would give frames of the wrong length.
- Start and done strobes that are wrongly merged or split would fail the L = 1 case, where both must coincide.

A long stretch in which the configuration changes every cycle, plus a reset applied in the middle of a frame, target a sequencer that latches its settings outside the settle cycle or leaves stale state behind after reset.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  // Width of the slot-length value; a slot lasts 1..3 slow-clock cycles.
  localparam int LEN_W = 2;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_CONV   = 2'd2
  } phase_t;

  // Filter-length code to slot length; the reserved code 3 acts as 2.
  function automatic logic [LEN_W-1:0] slot_len_of(input logic [1:0] code);
    case (code)
      2'd0:    slot_len_of = LEN_W'(1);
      2'd1:    slot_len_of = LEN_W'(2);
      default: slot_len_of = LEN_W'(3);
    endcase
  endfunction

endpackage

// File: rtl/mfs_cfg_latch.sv
module mfs_cfg_latch
  import mfs_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [1:0]       cfg_flen,
  output logic [CNT_W-1:0] cnt_eff,
  output logic [LEN_W-1:0] slot_len
);

  logic [CNT_W-1:0] cnt_clamped;

  // A count of zero would give an empty frame; clamp it to one slot.
  always_comb begin
    cnt_clamped = cfg_count;
    if (cfg_count == '0) cnt_clamped = CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_eff  <= CNT_W'(1);
      slot_len <= LEN_W'(1);
    end else if (load) begin
      cnt_eff  <= cnt_clamped;
      slot_len <= slot_len_of(cfg_flen);
    end
  end

  // R8: outside the settle cycle the latched configuration never moves.
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cnt_eff) && $stable(slot_len));

  // R7: the effective count is never zero.
  a_r7_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_eff != '0);

  // R6: the slot length stays within 1..3.
  a_r6_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    slot_len != '0);

endmodule

// File: rtl/mfs_sub_timer.sv
module mfs_sub_timer
  import mfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LEN_W-1:0] slot_len,
  output logic             first,
  output logic             last
);

  logic [LEN_W-1:0] sub;

  assign first = (sub == '0);
  assign last  = (sub == slot_len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub <= '0;
    end else if (!run || last) begin
      sub <= '0;
    end else begin
      sub <= sub + LEN_W'(1);
    end
  end

  // R4: the position inside a slot never reaches the slot length.
  a_r4_sub_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> sub < slot_len);

  // R5: after a slot's last cycle, the next running cycle opens a new slot.
  a_r5_first_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    run && last |=> !run || first);

endmodule

// File: rtl/mfs_frame_ctrl.sv
module mfs_frame_ctrl
  import mfs_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_eff,
  input  logic             slot_last,
  output phase_t           phase,
  output logic [CNT_W-1:0] slot
);

  logic final_slot;

  assign final_slot = (slot == cnt_eff - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      slot  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase <= PH_SETTLE;
          slot  <= '0;
        end
        PH_SETTLE: begin
          phase <= PH_CONV;
          slot  <= '0;
        end
        PH_CONV: begin
          if (slot_last) begin
            if (final_slot) begin
              phase <= PH_SETTLE;
              slot  <= '0;
            end else begin
              slot <= slot + CNT_W'(1);
            end
          end
        end
        default: begin
          phase <= PH_IDLE;
          slot  <= '0;
        end
      endcase
    end
  end

  // R2: the settle state lasts one cycle and is followed by conversion.
  a_r2_settle_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SETTLE |=> phase == PH_CONV);

  // R4: a slot index past the configured count never appears.
  a_r4_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_CONV |-> slot < cnt_eff);

  // R4: slots advance by one when a non-final slot ends.
  a_r4_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_CONV && slot_last && !final_slot |=> slot == $past(slot) + CNT_W'(1));

  // R9: the slot index reads 0 during settle.
  a_r9_slot_zero_settle: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SETTLE |-> slot == '0);

endmodule

// File: rtl/mux_frame_seq.sv
module mux_frame_seq
  import mfs_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [1:0]       cfg_flen,
  output logic             frame_sync,
  output logic             conv_active,
  output logic [CNT_W-1:0] mux_slot,
  output logic             conv_start,
  output logic             conv_done
);

  phase_t           phase;
  logic [CNT_W-1:0] cnt_eff;
  logic [LEN_W-1:0] slot_len;
  logic             slot_first;
  logic             slot_last;
  logic             in_conv;

  assign in_conv = (phase == PH_CONV);

  mfs_cfg_latch #(.CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (phase == PH_SETTLE),
    .cfg_count (cfg_count),
    .cfg_flen  (cfg_flen),
    .cnt_eff   (cnt_eff),
    .slot_len  (slot_len)
  );

  mfs_sub_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (in_conv),
    .slot_len (slot_len),
    .first    (slot_first),
    .last     (slot_last)
  );

  mfs_frame_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_eff   (cnt_eff),
    .slot_last (slot_last),
    .phase     (phase),
    .slot      (mux_slot)
  );

  assign frame_sync  = (phase == PH_SETTLE);
  assign conv_active = in_conv;
  assign conv_start  = in_conv && slot_first;
  assign conv_done   = in_conv && slot_last;

  // R2: sync is a single-cycle pulse.
  a_r2_sync_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> !frame_sync);

  // R2: sync and conversion never overlap.
  a_r2_sync_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_sync && conv_active));

  // R5: a done strobe is followed by a start strobe or by the settle cycle.
  a_r5_done_then_next: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> conv_start || frame_sync);

endmodule

// File: tb/mux_frame_seq_test.sv
`timescale 1ns/1ps
module mux_frame_seq_test;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cfg_count = '0;
  logic [1:0]    cfg_flen = 2'd0;
  logic          frame_sync, conv_active, conv_start, conv_done;
  logic [CW-1:0] mux_slot;

  int total = 0;
  int bad = 0;
  bit toggling = 1'b0;

  always #2 clk = ~clk;

  mux_frame_seq #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_count(cfg_count), .cfg_flen(cfg_flen),
    .frame_sync(frame_sync), .conv_active(conv_active), .mux_slot(mux_slot),
    .conv_start(conv_start), .conv_done(conv_done)
  );

  task automatic check(input string rq, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", rq, got, exp, $time);
    end
  endtask

  function automatic int len_of(input int code);
    if (code == 0) return 1;
    if (code == 1) return 2;
    return 3;
  endfunction

  // Position-in-frame model: position 0 is settle, 1..n*k are conversion cycles.
  bit m_on = 1'b0;
  int m_pos = 0, m_n = 1, m_k = 1, m_raw_n = 1, m_raw_f = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_on <= 1'b0; m_pos <= 0;
    end else if (!m_on) begin
      m_on <= 1'b1; m_pos <= 0;
    end else if (m_pos == 0) begin
      m_raw_n <= int'(cfg_count);
      m_raw_f <= int'(cfg_flen);
      m_n <= (cfg_count == '0) ? 1 : int'(cfg_count);
      m_k <= len_of(int'(cfg_flen));
      m_pos <= 1;
    end else if (m_pos == m_n * m_k) begin
      m_pos <= 0;
    end else begin
      m_pos <= m_pos + 1;
    end
  end

  int len_cnt = 0;
  bit have_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      // R1: outputs idle in reset
      check("R1", int'(frame_sync), 0);
      check("R1", int'(conv_active), 0);
      check("R1", int'(conv_start), 0);
      check("R1", int'(conv_done), 0);
      check("R1", int'(mux_slot), 0);
      have_prev = 1'b0;
      len_cnt = 0;
    end else begin
      bit e_fs, e_act;
      int p, e_slot, e_st, e_dn;
      e_fs  = m_on && (m_pos == 0);
      e_act = m_on && (m_pos > 0);
      p = m_pos - 1;
      e_slot = e_act ? p / m_k : 0;
      e_st = (e_act && (p % m_k == 0)) ? 1 : 0;
      e_dn = (e_act && (p % m_k == m_k - 1)) ? 1 : 0;
      check("R2", int'(frame_sync), int'(e_fs));
      check("R4", int'(conv_active), int'(e_act));
      if (e_fs) check("R9", int'(mux_slot), 0);
      else      check("R4", int'(mux_slot), e_slot);
      check("R5", int'(conv_start), e_st);
      check("R5", int'(conv_done), e_dn);
      if (frame_sync) begin
        if (have_prev) begin
          check("R3", len_cnt, 1 + m_n * m_k);
          check("R6", len_cnt, 1 + m_n * len_of(m_raw_f));
          if (m_raw_n == 0) check("R7", len_cnt, 1 + m_k);
          if (toggling) check("R8", len_cnt, 1 + m_n * m_k);
        end
        have_prev = 1'b1;
        len_cnt = 1;
      end else if (have_prev) begin
        len_cnt++;
      end
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic wait_syncs(input int nf);
    for (int i = 0; i < nf; i++) begin
      do @(negedge clk); while (!frame_sync);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int n = 0; n < 16; n++) begin
      for (int f = 0; f < 4; f++) begin
        @(posedge clk); #1;
        cfg_count = CW'(n);
        cfg_flen  = 2'(f);
        wait_syncs(3);
      end
    end
    // R1: reset in mid-frame, then restart from settle
    @(posedge clk); #1 cfg_count = CW'(5); cfg_flen = 2'd1;
    wait_syncs(1);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    wait_syncs(3);
    // R8: configuration changes every cycle; only settle-cycle values count
    toggling = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      cfg_count = CW'($urandom_range(0, 15));
      cfg_flen  = 2'($urandom_range(0, 3));
    end
    toggling = 1'b0;
    repeat (50) @(posedge clk);
    finish_run();
  end

endmodule